// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Encoder with Bubble Suppression

This block takes the raw comparator outputs of a flash analog-to-digital converter and turns them into a binary result. An N-bit converter has 2^N − 1 comparators. Each comparator reads 1 when the analog input lies above its reference tap and 0 when it lies below. The collected bits should therefore form a thermometer code: ones from the lowest tap upward, then zeros. Comparator noise and metastability can leave "bubbles" in that pattern, such as a lone high bit far above the true level or a lone low bit inside the run of ones.

Each bit is replaced by the majority vote of itself and its two neighbours before encoding. A single stray comparator then cannot move the result far. The corrected vector goes through a one-hot edge detector that keeps only the topmost 0-to-1 boundary, and an OR-tree encoder turns the edge position into binary. A flag reports any corrected vector that is still not a clean thermometer code. A sample-valid qualifier travels alongside the data. The output stage can be a register, which gives one clock of latency, or a plain combinational path; a parameter selects which.

Top module: `therm_flash_encoder`

## Requirements
- R1: Bit k of `therm_in` (k = 0 the lowest tap) is the comparator for tap k. For a clean thermometer input holding m ones in bits 0..m−1, `code_out` equals m. All zeros gives 0 and all ones gives 2^N − 1.
- R2: A bit that reads 1 while both of its neighbours read 0 is treated as 0 before encoding.
- R3: A bit that reads 0 while both of its neighbours read 1 is treated as 1 before encoding.
- R4: The vote at the edges uses a constant 1 below bit 0 and a constant 0 above the top bit. A lone 1 in bit 0 therefore survives as code 1, and a lone 1 in the top bit is removed and gives code 0.
- R5: If the corrected vector is not a thermometer code, `code_out` equals one plus the index of the highest corrected 1.
- R6: `bubble_err` is 1 exactly when the corrected vector holds a 0 directly below a 1.
- R7: With the registered output stage (the default), `code_out` and `bubble_err` reflect the input sampled at the previous rising clock edge and hold that value until the next edge.
- R8: `code_valid` repeats `sample_valid` with the same latency as `code_out`.
- R9: While `rst_n` is low, `code_out`, `code_valid` and `bubble_err` are 0. The reset is asynchronous.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_in | input | 2^N − 1 | Raw comparator bits, bit 0 = lowest tap |
| sample_valid | input | 1 | Qualifies `therm_in` in this cycle |
| code_out | output | N | Binary conversion result |
| code_valid | output | 1 | Qualifier for `code_out` |
| bubble_err | output | 1 | Corrected vector still not a thermometer code |

## Verification
In the default registered mode, every result (`code_out`, `bubble_err` and `code_valid`) is due one rising edge after its stimulus. The bench drives each input on a falling edge and reads the matching result on the following falling edge, which is the first edge after the register has loaded. For R7 it also samples once just before the rising edge, to confirm that the previous result is still held. Reset clearing is checked shortly after `rst_n` falls, with no clock edge in between, because the reset does not wait for the clock.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/therm_bubble_vote.sv
module therm_bubble_vote #(
   parameter int TAPS = 15
) (
   input  logic [TAPS-1:0] raw_i,
   output logic [TAPS-1:0] fixed_o
);
   import therm_enc_pkg::*;

   // padded[0] is the constant-1 floor, padded[TAPS+1] the constant-0 ceiling
   logic [TAPS+1:0] padded;
   assign padded = {1'b0, raw_i, 1'b1};

   for (genvar k = 0; k < TAPS; k++) begin : g_vote
      assign fixed_o[k] = maj3(padded[k], padded[k+1], padded[k+2]);
   end
endmodule

// File: rtl/therm_edge_find.sv
module therm_edge_find #(
   parameter int TAPS = 15
) (
   input  logic [TAPS-1:0] level_i,
   output logic [TAPS:0]   edge_o
);
   // ext[j] = 1 when at least j taps are asserted; ext[0] is always true
   logic [TAPS:0]   ext;
   logic [TAPS+1:0] any_above;

   assign ext = {level_i, 1'b1};
   assign any_above[TAPS+1] = 1'b0;

   for (genvar j = TAPS; j >= 0; j--) begin : g_chain
      assign any_above[j] = ext[j] | any_above[j+1];
      assign edge_o[j]    = ext[j] & ~any_above[j+1];
   end
endmodule

// File: rtl/therm_or_encode.sv
module therm_or_encode #(
   parameter int CW = 4
) (
   input  logic [(1<<CW)-1:0] onehot_i,
   output logic [CW-1:0]      bin_o
);
   localparam int LINES = 1 << CW;

   for (genvar b = 0; b < CW; b++) begin : g_bit
      logic [LINES-1:0] sel;
      for (genvar j = 0; j < LINES; j++) begin : g_line
         assign sel[j] = ((j >> b) & 1) != 0 ? onehot_i[j] : 1'b0;
      end
      assign bin_o[b] = |sel;
   end
endmodule

// File: rtl/therm_flash_encoder.sv
module therm_flash_encoder #(
   parameter int                       NBITS    = 4,
   parameter therm_enc_pkg::out_mode_e OUT_MODE = therm_enc_pkg::OUT_REG
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<NBITS)-2:0]   therm_in,
   input  logic                    sample_valid,
   output logic [NBITS-1:0]        code_out,
   output logic                    code_valid,
   output logic                    bubble_err
);
   import therm_enc_pkg::*;

   localparam int TAPS = (1 << NBITS) - 1;
   localparam logic [NBITS-1:0] CODE_MAX = NBITS'(TAPS);

   if (NBITS < 2 || NBITS > 10) begin : g_bad_width
      $error("therm_flash_encoder: NBITS must lie in 2..10");
   end

   logic [TAPS-1:0] voted;
   logic [TAPS:0]   top_edge;
   logic [NBITS-1:0] code_c;
   logic            err_c;

   therm_bubble_vote #(.TAPS(TAPS)) u_vote (
      .raw_i   (therm_in),
      .fixed_o (voted)
   );

   therm_edge_find #(.TAPS(TAPS)) u_edge (
      .level_i (voted),
      .edge_o  (top_edge)
   );

   therm_or_encode #(.CW(NBITS)) u_enc (
      .onehot_i (top_edge),
      .bin_o    (code_c)
   );

   // a 0 sitting directly under a 1 means the vote left a broken pattern
   assign err_c = |(~voted[TAPS-2:0] & voted[TAPS-1:1]);

   if (OUT_MODE == OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_out   <= '0;
            code_valid <= 1'b0;
            bubble_err <= 1'b0;
         end else begin
            code_out   <= code_c;
            code_valid <= sample_valid;
            bubble_err <= err_c;
         end
      end

      AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
         sample_valid |=> code_valid) else $error("valid not carried"); // R8
      AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
         !sample_valid |=> !code_valid) else $error("valid spurious"); // R8
      AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
         (&therm_in) |=> (code_out == CODE_MAX && !bubble_err)) else $error("full scale"); // R1
      AST_EMPTY_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
         (therm_in == '0) |=> (code_out == '0 && !bubble_err)) else $error("zero scale"); // R1
      AST_TOP_LONE: assert property (@(posedge clk) disable iff (!rst_n)
         (therm_in == {1'b1, {(TAPS-1){1'b0}}}) |=> (code_out == '0)) else $error("top lone"); // R4
      AST_ERR_CODE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
         bubble_err |-> (code_out >= NBITS'(2))) else $error("err with low code"); // R6
   end else begin : g_comb
      assign code_out   = rst_n ? code_c : '0;
      assign code_valid = rst_n ? sample_valid : 1'b0;
      assign bubble_err = rst_n ? err_c : 1'b0;

      AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
         (&therm_in) |-> (code_out == CODE_MAX)) else $error("full scale"); // R1
   end

   AST_EDGE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(top_edge)) else $error("edge not one-hot"); // R5
endmodule

// File: tb/therm_flash_encoder_tb.sv
module therm_flash_encoder_tb;
   localparam int PERIOD = 10;
   localparam int NB     = 4;
   localparam int TAPS   = (1 << NB) - 1;
   localparam int NVEC   = 14;

   // {stimulus, expected code, expected error flag}
   localparam logic [TAPS+NB:0] VEC [NVEC] = '{
      {15'h0000, 4'd0,  1'b0},  // R1 empty
      {15'h7FFF, 4'd15, 1'b0},  // R1 full
      {15'h00FF, 4'd8,  1'b0},  // R1 mid
      {15'h0001, 4'd1,  1'b0},  // R4 floor kept
      {15'h4000, 4'd0,  1'b0},  // R4 lone top removed
      {15'h047F, 4'd7,  1'b0},  // R2 stray high
      {15'h00F7, 4'd8,  1'b0},  // R3 hole filled
      {15'h0005, 4'd2,  1'b0},  // R3 low hole
      {15'h3FFF, 4'd14, 1'b0},  // R1 near top
      {15'h7FFE, 4'd15, 1'b0},  // R4 bit0 hole
      {15'h5FFF, 4'd14, 1'b0},  // R2 top stray after hole
      {15'h0303, 4'd10, 1'b1},  // R5 R6 pair stray
      {15'h1F1F, 4'd13, 1'b1},  // R5 R6 two runs
      {15'h5555, 4'd14, 1'b1}   // R5 R6 alternating
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [TAPS-1:0] therm_in = '0;
   logic            sample_valid = 1'b0;
   logic [NB-1:0]   code_out;
   logic            code_valid;
   logic            bubble_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   therm_flash_encoder #(.NBITS(NB)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .therm_in     (therm_in),
      .sample_valid (sample_valid),
      .code_out     (code_out),
      .code_valid   (code_valid),
      .bubble_err   (bubble_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin
      #(PERIOD*5000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      therm_in = 15'h7FFF;
      sample_valid = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 reset code", code_out, 0);
      check("R9 reset valid", code_valid, 0);
      check("R9 reset err", bubble_err, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         therm_in = VEC[i][TAPS+NB:NB+1];
         sample_valid = 1'b1;
         @(negedge clk);
         check($sformatf("R1/R2/R3/R4/R5 code vec%0d", i), code_out, int'(VEC[i][NB:1]));
         check($sformatf("R6 err vec%0d", i), bubble_err, int'(VEC[i][0]));
         check($sformatf("R8 valid vec%0d", i), code_valid, 1);
      end

      // R7: result held until the next rising edge
      @(negedge clk);
      therm_in = 15'h00FF;
      @(negedge clk);
      check("R7 new code", code_out, 8);
      therm_in = 15'h0003;
      sample_valid = 1'b0;
      #(PERIOD/2 - 1);
      check("R7 held before edge", code_out, 8);
      check("R8 valid held before edge", code_valid, 1);
      @(negedge clk);
      check("R7 updated after edge", code_out, 2);
      check("R8 valid dropped", code_valid, 0);

      // R9: asynchronous reset mid-stream
      therm_in = 15'h1F1F;
      sample_valid = 1'b1;
      @(negedge clk);
      check("R6 err before reset", bubble_err, 1);
      rst_n = 1'b0;
      #1;
      check("R9 async code", code_out, 0);
      check("R9 async valid", code_valid, 0);
      check("R9 async err", bubble_err, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 code after reset", code_out, 13);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule